// File: doc/BRIEF.md
# Dual-Function Card Control Register

This block keeps the card control byte for a two-socket card controller that presents two configuration functions. Each function owns a copy of the byte at configuration offset 0x91. Software reaches both copies through a byte-wide configuration port that carries a function number, an address, a write strobe and write data. Read data is combinational and follows the addressed function and offset in the same cycle.

Most fields belong to one socket: an audio routing request, a speaker enable, four spare storage bits and a sticky interrupt flag. The ring-indicate output enable is different. It is a single global bit that is stored once and can be reached only through function 0. The block combines the speaker signals of both sockets into one speaker output with its own output enable. It also picks which socket's audio goes to the multifunction pin.

Each function has a soft reset input, which clears only that function's spare bits. Every control and flag bit is cleared only by the global reset. The configuration port has no back-pressure: a write is taken on every clock edge where its strobe is high. The interrupt inputs, speaker inputs and all outputs are plain level signals with no handshake.

Top module: `cardctl_top`

## Requirements
- R1: After the global reset (grst_n low, asynchronous), both register copies read 0x00, ring_out_en is 0, spkr_oe is 0, spkr_out is 0, audio_routed is 1 and audio_src is 0.
- R2: A write to offset 0x91 of a function with cfg_wr high updates that function's copy at the next rising clock edge. cfg_rdata returns the addressed copy when cfg_addr is 0x91. A write to any other offset changes nothing, and a read of any other offset returns 0x00.
- R3: Bit 7 is the global ring-indicate enable and drives ring_out_en. Only a write through function 0 changes it. A write through function 1 leaves it unchanged, and a read through function 1 returns 0 in bit 7.
- R4: Bits 6 to 3 are spare storage in each function and read back as written. A pulse on func_soft_rst[i] clears these four bits of function i only.
- R5: Bit 2 set to 0 means that function's socket asks for its audio on the multifunction pin; 1 means no request. audio_routed is 1 when any function asks. audio_src gives the lowest-numbered function that asks, so function 0 wins, and it is 0 when no function asks.
- R6: spkr_out is the XOR of spkr_in[i] over every function i whose bit 1 (speaker enable) is 1. A socket whose enable is 0 contributes 0.
- R7: spkr_oe is 1 exactly when bit 1 is 1 in at least one function. spkr_out is 0 whenever spkr_oe is 0.
- R8: Bit 0 of function i is set by a high card_irq[i] at a clock edge. A write of 1 to bit 0 clears it, and a write of 0 to bit 0 leaves it unchanged.
- R9: If card_irq[i] is high on the same edge as a write of 1 to bit 0 of function i, the flag is 1 after that edge.
- R10: A soft reset does not change bits 7, 2, 1 or 0 of any function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst_n | input | 1 | Global reset, active low, asynchronous |
| cfg_func | input | FUNC_W | Function number of the configuration access |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the addressed function and offset |
| func_soft_rst | input | N_FUNC | Per-function soft reset pulse |
| card_irq | input | N_FUNC | Per-socket functional interrupt |
| spkr_in | input | N_FUNC | Per-socket speaker signal |
| ring_out_en | output | 1 | Ring-indicate output enable |
| spkr_out | output | 1 | Combined speaker output |
| spkr_oe | output | 1 | Speaker output drive enable |
| audio_routed | output | 1 | Some socket's audio goes to the multifunction pin |
| audio_src | output | FUNC_W | Socket whose audio is routed |

## Verification
The bench builds the block with its defaults: two functions and offset 0x91. With two functions, the bench can make the global bit visible through function 0 and hidden through function 1. It can also set up every combination of the two speaker enables, and have both functions request audio routing at once so the priority rule decides. A shared edge between an interrupt and a clearing write is driven on purpose, as are soft resets on a function whose flag and control bits are already set.

// File: rtl/cardctl_pkg.sv
package cardctl_pkg;
  localparam int RING_BIT = 7;
  localparam int SPARE_HI = 6;
  localparam int SPARE_LO = 3;
  localparam int AUD_BIT  = 2;
  localparam int SPK_BIT  = 1;
  localparam int FLAG_BIT = 0;
  localparam int SPARE_W  = SPARE_HI - SPARE_LO + 1;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic               aud_off;
    logic               spk_en;
    logic               flag;
  } fn_bits_t;
endpackage

// File: rtl/cardctl_fn_reg.sv
module cardctl_fn_reg
  import cardctl_pkg::*;
(
  input  logic     clk,
  input  logic     grst_n,
  input  logic     wr_hit,
  input  logic [7:0] wdata,
  input  logic     soft_rst,
  input  logic     irq,
  output fn_bits_t q
);
  always_ff @(posedge clk or negedge grst_n) begin
    if (!grst_n) begin
      q <= '0;
    end else begin
      if (soft_rst)
        q.spare <= '0;
      else if (wr_hit)
        q.spare <= wdata[SPARE_HI:SPARE_LO];
      if (wr_hit) begin
        q.aud_off <= wdata[AUD_BIT];
        q.spk_en  <= wdata[SPK_BIT];
      end
      if (irq)
        q.flag <= 1'b1;
      else if (wr_hit && wdata[FLAG_BIT])
        q.flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cardctl_spkr_mix.sv
module cardctl_spkr_mix #(
  parameter int N_FUNC = 2
) (
  input  logic [N_FUNC-1:0] spkr_in,
  input  logic [N_FUNC-1:0] en,
  output logic              spkr_out,
  output logic              spkr_oe
);
  logic mix;
  always_comb begin
    mix = 1'b0;
    for (int i = 0; i < N_FUNC; i++)
      mix = mix ^ (spkr_in[i] & en[i]);
  end
  assign spkr_oe  = |en;
  assign spkr_out = mix & spkr_oe;
endmodule

// File: rtl/cardctl_audio_sel.sv
module cardctl_audio_sel #(
  parameter int N_FUNC = 2,
  parameter int FUNC_W = 1
) (
  input  logic [N_FUNC-1:0] req,
  output logic              routed,
  output logic [FUNC_W-1:0] src
);
  always_comb begin
    src = '0;
    for (int i = N_FUNC - 1; i >= 0; i--)
      if (req[i]) src = FUNC_W'(i);
  end
  assign routed = |req;
endmodule

// File: rtl/cardctl_top.sv
module cardctl_top
  import cardctl_pkg::*;
#(
  parameter int N_FUNC = 2,
  parameter logic [7:0] REG_OFS = 8'h91,
  localparam int FUNC_W = (N_FUNC > 1) ? $clog2(N_FUNC) : 1
) (
  input  logic              clk,
  input  logic              grst_n,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [N_FUNC-1:0] func_soft_rst,
  input  logic [N_FUNC-1:0] card_irq,
  input  logic [N_FUNC-1:0] spkr_in,
  output logic              ring_out_en,
  output logic              spkr_out,
  output logic              spkr_oe,
  output logic              audio_routed,
  output logic [FUNC_W-1:0] audio_src
);
  logic                   addr_hit;
  logic                   func_ok;
  fn_bits_t               fn_q [N_FUNC];
  logic [N_FUNC-1:0]      fn_flag;
  logic [N_FUNC-1:0]      fn_spk_en;
  logic [N_FUNC-1:0]      aud_req;
  logic [N_FUNC-1:0][SPARE_W-1:0] fn_spare;
  logic                   ring_q;

  assign addr_hit = (cfg_addr == REG_OFS);
  assign func_ok  = (int'(cfg_func) < N_FUNC);

  for (genvar g = 0; g < N_FUNC; g++) begin : g_fn
    logic wr_hit;
    assign wr_hit = cfg_wr && addr_hit && (cfg_func == FUNC_W'(g));
    cardctl_fn_reg u_reg (
      .clk      (clk),
      .grst_n   (grst_n),
      .wr_hit   (wr_hit),
      .wdata    (cfg_wdata),
      .soft_rst (func_soft_rst[g]),
      .irq      (card_irq[g]),
      .q        (fn_q[g])
    );
    assign fn_flag[g]   = fn_q[g].flag;
    assign fn_spk_en[g] = fn_q[g].spk_en;
    assign aud_req[g]   = ~fn_q[g].aud_off;
    assign fn_spare[g]  = fn_q[g].spare;
  end

  // global ring enable lives once, written only through function 0
  always_ff @(posedge clk or negedge grst_n) begin
    if (!grst_n)
      ring_q <= 1'b0;
    else if (cfg_wr && addr_hit && cfg_func == '0)
      ring_q <= cfg_wdata[RING_BIT];
  end
  assign ring_out_en = ring_q;

  always_comb begin
    cfg_rdata = 8'h00;
    for (int i = 0; i < N_FUNC; i++) begin
      if (addr_hit && func_ok && cfg_func == FUNC_W'(i)) begin
        cfg_rdata[SPARE_HI:SPARE_LO] = fn_q[i].spare;
        cfg_rdata[AUD_BIT]  = fn_q[i].aud_off;
        cfg_rdata[SPK_BIT]  = fn_q[i].spk_en;
        cfg_rdata[FLAG_BIT] = fn_q[i].flag;
        cfg_rdata[RING_BIT] = (i == 0) ? ring_q : 1'b0;
      end
    end
  end

  cardctl_spkr_mix #(.N_FUNC(N_FUNC)) u_spkr (
    .spkr_in  (spkr_in),
    .en       (fn_spk_en),
    .spkr_out (spkr_out),
    .spkr_oe  (spkr_oe)
  );

  cardctl_audio_sel #(.N_FUNC(N_FUNC), .FUNC_W(FUNC_W)) u_aud (
    .req    (aud_req),
    .routed (audio_routed),
    .src    (audio_src)
  );
endmodule

// File: rtl/cardctl_checker.sv
module cardctl_checker
  import cardctl_pkg::*;
#(
  parameter int N_FUNC = 2,
  parameter logic [7:0] REG_OFS = 8'h91,
  parameter int FUNC_W = 1
) (
  input logic              clk,
  input logic              grst_n,
  input logic [FUNC_W-1:0] cfg_func,
  input logic [7:0]        cfg_addr,
  input logic              cfg_wr,
  input logic [7:0]        cfg_wdata,
  input logic [N_FUNC-1:0] func_soft_rst,
  input logic [N_FUNC-1:0] card_irq,
  input logic              ring_out_en,
  input logic              spkr_out,
  input logic              spkr_oe,
  input logic [N_FUNC-1:0] fn_flag,
  input logic [N_FUNC-1:0] fn_spk_en,
  input logic [N_FUNC-1:0][SPARE_W-1:0] fn_spare
);
  p_ring_other_fn_r3: assert property (@(posedge clk) disable iff (!grst_n)
    (cfg_wr && cfg_func != '0) |=> $stable(ring_out_en));

  p_spkr_quiet_r7: assert property (@(posedge clk) disable iff (!grst_n)
    !spkr_oe |-> !spkr_out);

  for (genvar g = 0; g < N_FUNC; g++) begin : g_chk
    logic wr_me;
    assign wr_me = cfg_wr && cfg_addr == REG_OFS && cfg_func == FUNC_W'(g);

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!grst_n)
      card_irq[g] |=> fn_flag[g]);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!grst_n)
      (wr_me && cfg_wdata[FLAG_BIT] && !card_irq[g]) |=> !fn_flag[g]);

    p_soft_spare_r4: assert property (@(posedge clk) disable iff (!grst_n)
      func_soft_rst[g] |=> fn_spare[g] == '0);

    p_soft_keep_r10: assert property (@(posedge clk) disable iff (!grst_n)
      (func_soft_rst[g] && !wr_me && !card_irq[g])
        |=> ($stable(fn_flag[g]) && $stable(fn_spk_en[g])));
  end
endmodule

bind cardctl_top cardctl_checker #(
  .N_FUNC(N_FUNC), .REG_OFS(REG_OFS), .FUNC_W(FUNC_W)
) u_chk (
  .clk(clk), .grst_n(grst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
  .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .func_soft_rst(func_soft_rst),
  .card_irq(card_irq), .ring_out_en(ring_out_en), .spkr_out(spkr_out),
  .spkr_oe(spkr_oe), .fn_flag(fn_flag), .fn_spk_en(fn_spk_en),
  .fn_spare(fn_spare)
);

// File: tb/cardctl_top_test.sv
module cardctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] OFS = 8'h91;

  logic       clk = 1'b0;
  logic       grst_n = 1'b0;
  logic [0:0] cfg_func = '0;
  logic [7:0] cfg_addr = OFS;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [1:0] func_soft_rst = '0;
  logic [1:0] card_irq = '0;
  logic [1:0] spkr_in = '0;
  logic       ring_out_en, spkr_out, spkr_oe, audio_routed;
  logic [0:0] audio_src;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cardctl_top uut (
    .clk(clk), .grst_n(grst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .func_soft_rst(func_soft_rst), .card_irq(card_irq), .spkr_in(spkr_in),
    .ring_out_en(ring_out_en), .spkr_out(spkr_out), .spkr_oe(spkr_oe),
    .audio_routed(audio_routed), .audio_src(audio_src)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one clock with the given strobes, inputs changed at the falling edge
  task automatic cycle_with(bit wr, bit f, logic [7:0] a, logic [7:0] d,
                            logic [1:0] srst, logic [1:0] irq);
    @(negedge clk);
    cfg_wr = wr; cfg_func = f; cfg_addr = a; cfg_wdata = d;
    func_soft_rst = srst; card_irq = irq;
    @(negedge clk);
    cfg_wr = 0; func_soft_rst = '0; card_irq = '0; cfg_addr = OFS;
  endtask

  task automatic wr(bit f, logic [7:0] d);
    cycle_with(1, f, OFS, d, 2'b00, 2'b00);
  endtask

  task automatic rd(bit f, logic [7:0] a, output logic [7:0] v);
    cfg_func = f; cfg_addr = a;
    #1 v = cfg_rdata;
    cfg_addr = OFS;
  endtask

  task automatic do_reset();
    @(negedge clk);
    grst_n = 0;
    #2 grst_n = 0;
    @(negedge clk);
    grst_n = 1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, OFS, v); check("R1 f0 read", v, 8'h00);
    rd(1, OFS, v); check("R1 f1 read", v, 8'h00);
    check("R1 ring", ring_out_en, 0);
    check("R1 spkr_oe", spkr_oe, 0);
    check("R1 spkr_out", spkr_out, 0);
    check("R1 routed", audio_routed, 1);
    check("R1 src", audio_src, 0);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    wr(0, 8'h80);
    check("R3 ring set f0", ring_out_en, 1);
    rd(0, OFS, v); check("R3 f0 bit7", v, 8'h80);
    rd(1, OFS, v); check("R3 f1 hides bit7", v, 8'h00);
    wr(1, 8'h00);
    check("R3 f1 write no clear", ring_out_en, 1);
    wr(0, 8'h00);
    check("R3 ring clear f0", ring_out_en, 0);
    wr(1, 8'h80);
    check("R3 f1 write no set", ring_out_en, 0);
    rd(1, OFS, v); check("R3 f1 bit7 zero", v, 8'h00);
    wr(1, 8'h00);
  endtask

  task automatic t_offset();
    logic [7:0] v;
    cycle_with(1, 0, 8'h90, 8'hFE, 2'b00, 2'b00);
    rd(0, OFS, v); check("R2 other offset write ignored", v, 8'h00);
    check("R2 ring untouched", ring_out_en, 0);
    wr(0, 8'h28);
    rd(0, 8'h92, v); check("R2 other offset reads 0", v, 8'h00);
    rd(0, OFS, v); check("R2 readback", v, 8'h28);
    wr(0, 8'h00);
  endtask

  task automatic t_soft();
    logic [7:0] v;
    wr(0, 8'hFE);
    wr(1, 8'h50);
    rd(0, OFS, v); check("R4 f0 spare", v, 8'hFE);
    rd(1, OFS, v); check("R4 f1 spare", v, 8'h50);
    cycle_with(0, 0, OFS, 8'h00, 2'b01, 2'b00);
    rd(0, OFS, v); check("R10 f0 after soft reset", v, 8'h86);
    rd(1, OFS, v); check("R4 f1 untouched", v, 8'h50);
    check("R10 ring kept", ring_out_en, 1);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_audio();
    wr(0, 8'h04);
    check("R5 f1 only routed", audio_routed, 1);
    check("R5 f1 src", audio_src, 1);
    wr(1, 8'h04);
    check("R5 none routed", audio_routed, 0);
    wr(0, 8'h00); wr(1, 8'h00);
    check("R5 both ask f0 wins", audio_src, 0);
  endtask

  task automatic t_speaker();
    wr(1, 8'h02);
    spkr_in = 2'b10; #1;
    check("R7 oe one enable", spkr_oe, 1);
    check("R6 f1 only", spkr_out, 1);
    spkr_in = 2'b11; #1;
    check("R6 disabled f0 contributes 0", spkr_out, 1);
    wr(0, 8'h02);
    spkr_in = 2'b11; #1;
    check("R6 xor both", spkr_out, 0);
    spkr_in = 2'b01; #1;
    check("R6 xor one", spkr_out, 1);
    wr(0, 8'h00); wr(1, 8'h00);
    check("R7 oe off", spkr_oe, 0);
    check("R7 out quiet", spkr_out, 0);
    spkr_in = 2'b00;
  endtask

  task automatic t_flag();
    logic [7:0] v;
    cycle_with(0, 0, OFS, 8'h00, 2'b00, 2'b10);
    rd(1, OFS, v); check("R8 f1 flag set", v, 8'h01);
    rd(0, OFS, v); check("R8 f0 flag clear", v, 8'h00);
    wr(1, 8'h00);
    rd(1, OFS, v); check("R8 write 0 keeps", v, 8'h01);
    wr(1, 8'h01);
    rd(1, OFS, v); check("R8 write 1 clears", v, 8'h00);
    cycle_with(0, 0, OFS, 8'h00, 2'b00, 2'b01);
    cycle_with(1, 0, OFS, 8'h01, 2'b00, 2'b01);
    rd(0, OFS, v); check("R9 set beats clear", v, 8'h01);
    cycle_with(0, 0, OFS, 8'h00, 2'b01, 2'b00);
    rd(0, OFS, v); check("R10 soft keeps flag", v, 8'h01);
    wr(0, 8'h01);
    rd(0, OFS, v); check("R8 f0 cleared", v, 8'h00);
  endtask

  task automatic t_greset();
    wr(0, 8'hFA);
    cycle_with(0, 0, OFS, 8'h00, 2'b00, 2'b11);
    do_reset();
    t_reset();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    grst_n = 1;
    t_reset();
    t_ring();
    t_offset();
    t_soft();
    t_audio();
    t_speaker();
    t_flag();
    t_greset();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule